// File: doc/BRIEF.md
# Flash program/erase control sequencer

This block holds the 16-bit control register through which software starts self-timed program and erase operations on an on-chip nonvolatile array. Software first writes an operation code, an erase/program selector and a write-enable bit. It then writes the register again with the start bit set. The block checks the request and, when the request is legal, pulses a start strobe to the array and presents the operation type. It then holds a busy signal for a duration chosen per operation type. When the count runs out, it clears the start bit by itself.

Requests that are improper, and operations that are cut short by an abort input, set a sticky error flag. An implemented code paired with the wrong erase/program selector starts nothing and raises no error. Bulk erase is accepted only while an external programming-mode input is high. The block has only one reset, and that reset acts as the power-on reset.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: After reset, rd_data_o reads 0 and flash_start_o, flash_busy_o and done_o are low.
- R2: The register layout is: bit 15 start, bit 14 write enable, bit 13 error, bit 6 erase selector (1 = erase), bits 3:0 operation code. Bits 12:7 and 5:4 always read 0. While start is 0, a write with bit 15 clear loads bits 14, 13, 6 and 3:0 exactly as written.
- R3: A write with bit 15 set while start is 0 is a start attempt, judged on the fields of that same write. The attempt is bad when write enable is 0, when the code is none of 4'h1, 4'h2, 4'h3, 4'hF, or when it requests bulk erase (erase=1, code 4'hF) while prog_mode_i is low. A bad attempt sets the error bit, gives no flash_start_o, and leaves the start bit high for exactly one cycle.
- R4: An implemented code paired with the wrong selector is a no-op: erase=1 with 4'h1 or 4'h3, or erase=0 with 4'h2 or 4'hF. A no-op gives no flash_start_o, leaves the error bit unchanged, and keeps start high for exactly one cycle.
- R5: A legal attempt pulses flash_start_o for one cycle, in the cycle after the write edge. flash_op_o shows the operation in that cycle: 0 = word program (erase=0, 4'h3), 1 = row program (erase=0, 4'h1), 2 = page erase (erase=1, 4'h2), 3 = bulk erase (erase=1, 4'hF). flash_busy_o is high in that same cycle.
- R6: After a legal attempt, start and flash_busy_o stay high for exactly T_WORD, T_ROW, T_PAGE or T_BULK cycles, depending on the operation. done_o is then high for one cycle as start reads 0, and the error bit is unchanged.
- R7: While start reads 1, register writes have no effect on any bit, including bits 15 and 13.
- R8: If abort_i is high in a busy cycle, start and flash_busy_o read 0 in the next cycle, the error bit is set, and done_o stays low. Abort wins over expiry in the same cycle. abort_i has no effect while the block is idle.
- R9: The error bit is sticky: a start attempt never clears it. Only an idle write with bit 15 clear changes it, and that write loads bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read value |
| prog_mode_i | input | 1 | External programming mode; permits bulk erase |
| abort_i | input | 1 | Ends a running operation early |
| flash_start_o | output | 1 | One-cycle start strobe to the array |
| flash_op_o | output | 2 | Operation type for the array |
| flash_busy_o | output | 1 | Array operation in progress |
| done_o | output | 1 | One-cycle pulse on normal completion |

## Verification
Each register write registers on one clock edge. The new fields, the start bit and the error bit appear in the cycle after that edge, and so does flash_start_o. The bench drives inputs on falling edges and samples on the next falling edge, so each of these results is read in the first cycle after the write. From that sample, the bench counts the falling edges during which start stays high and compares the count with the expected duration: the parameter for a legal operation, and one cycle for a bad attempt or a no-op. It reads done_o at the first sample where start is low. Abort results are read one cycle after the abort cycle.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  typedef enum logic [1:0] {
    OP_WORD = 2'd0,
    OP_ROW  = 2'd1,
    OP_PAGE = 2'd2,
    OP_BULK = 2'd3
  } nvm_op_e;

  localparam int unsigned GO_BIT  = 15;
  localparam int unsigned ARM_BIT = 14;
  localparam int unsigned ERR_BIT = 13;
  localparam int unsigned ERS_BIT = 6;

  localparam logic [3:0] CODE_ROW  = 4'h1;
  localparam logic [3:0] CODE_PAGE = 4'h2;
  localparam logic [3:0] CODE_WORD = 4'h3;
  localparam logic [3:0] CODE_BULK = 4'hF;
endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
  import nvm_seq_pkg::*;
(
  input  logic       erase_i,
  input  logic [3:0] code_i,
  input  logic       prog_mode_i,
  output logic       impl_o,
  output logic       noop_o,
  output logic       locked_o,
  output nvm_op_e    op_o
);
  always_comb begin
    impl_o   = 1'b1;
    noop_o   = 1'b0;
    locked_o = 1'b0;
    op_o     = OP_WORD;
    unique case (code_i)
      CODE_WORD: begin op_o = OP_WORD; noop_o = erase_i;  end
      CODE_ROW:  begin op_o = OP_ROW;  noop_o = erase_i;  end
      CODE_PAGE: begin op_o = OP_PAGE; noop_o = !erase_i; end
      CODE_BULK: begin
        op_o     = OP_BULK;
        noop_o   = !erase_i;
        locked_o = erase_i && !prog_mode_i;
      end
      default:   impl_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             cancel_i,
  output logic             run_o,
  output logic             expire_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign run_o    = run_q;
  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= load_val_i;
    end else if (run_q) begin
      if (cancel_i || cnt_q == '0) run_q <= 1'b0;
      else                         cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
  import nvm_seq_pkg::*;
#(
  parameter int unsigned T_WORD = 3,
  parameter int unsigned T_ROW  = 5,
  parameter int unsigned T_PAGE = 7,
  parameter int unsigned T_BULK = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  input  logic        prog_mode_i,
  input  logic        abort_i,
  output logic        flash_start_o,
  output logic [1:0]  flash_op_o,
  output logic        flash_busy_o,
  output logic        done_o
);
  localparam int unsigned T_MAX_A = (T_WORD > T_ROW)  ? T_WORD : T_ROW;
  localparam int unsigned T_MAX_B = (T_PAGE > T_BULK) ? T_PAGE : T_BULK;
  localparam int unsigned T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int unsigned CNT_W   = $clog2(T_MAX + 1);

  logic       go_q, arm_q, err_q, ers_q, start_q, done_q;
  logic [3:0] code_q;
  nvm_op_e    op_q;

  logic       impl, noop, locked, bad, attempt, fire, run, expire;
  nvm_op_e    dec_op;
  logic [CNT_W-1:0] load_val;

  logic unused_wdata;
  assign unused_wdata = ^{wr_data_i[12:7], wr_data_i[5:4]};

  nvm_cmd_decode u_dec (
    .erase_i     (wr_data_i[ERS_BIT]),
    .code_i      (wr_data_i[3:0]),
    .prog_mode_i (prog_mode_i),
    .impl_o      (impl),
    .noop_o      (noop),
    .locked_o    (locked),
    .op_o        (dec_op)
  );

  assign attempt = wr_en_i && !go_q && wr_data_i[GO_BIT];
  assign bad     = !wr_data_i[ARM_BIT] || !impl || locked;
  assign fire    = attempt && !bad && !noop;

  always_comb begin
    unique case (dec_op)
      OP_WORD: load_val = CNT_W'(T_WORD - 1);
      OP_ROW:  load_val = CNT_W'(T_ROW - 1);
      OP_PAGE: load_val = CNT_W'(T_PAGE - 1);
      default: load_val = CNT_W'(T_BULK - 1);
    endcase
  end

  nvm_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fire),
    .load_val_i (load_val),
    .cancel_i   (abort_i),
    .run_o      (run),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q    <= 1'b0;
      arm_q   <= 1'b0;
      err_q   <= 1'b0;
      ers_q   <= 1'b0;
      code_q  <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= OP_WORD;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      if (go_q) begin
        // rejected or no-op attempts hold start for one cycle only
        if (!run) go_q <= 1'b0;
        else if (abort_i) begin
          go_q  <= 1'b0;
          err_q <= 1'b1;
        end else if (expire) begin
          go_q   <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (wr_en_i) begin
        arm_q  <= wr_data_i[ARM_BIT];
        ers_q  <= wr_data_i[ERS_BIT];
        code_q <= wr_data_i[3:0];
        if (wr_data_i[GO_BIT]) begin
          go_q  <= 1'b1;
          err_q <= err_q | bad;
          if (fire) begin
            start_q <= 1'b1;
            op_q    <= dec_op;
          end
        end else begin
          err_q <= wr_data_i[ERR_BIT];
        end
      end
    end
  end

  assign rd_data_o     = {go_q, arm_q, err_q, 6'b0, ers_q, 2'b0, code_q};
  assign flash_start_o = start_q;
  assign flash_op_o    = op_q;
  assign flash_busy_o  = run;
  assign done_o        = done_q;
endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        prog_mode_i,
  input logic        abort_i,
  input logic        flash_start_o,
  input logic [1:0]  flash_op_o,
  input logic        flash_busy_o,
  input logic        done_o
);
  always_comb begin
    assert_unimpl_zero_R2: assert (!rst_ni || (rd_data_o[12:7] == '0 && rd_data_o[5:4] == '0));
  end

  assert_start_is_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_start_o |=> !flash_start_o);

  assert_start_with_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_start_o |-> (flash_busy_o && rd_data_o[15]));

  assert_busy_implies_go_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_busy_o |-> rd_data_o[15]);

  assert_done_after_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_data_o[15] && !flash_busy_o && !done_o == 1'b0));

  assert_fields_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[15] |=> $stable({rd_data_o[14], rd_data_o[6], rd_data_o[3:0]}));

  assert_abort_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_busy_o && abort_i) |=> (!rd_data_o[15] && rd_data_o[13] && !done_o && !flash_busy_o));

  assert_bulk_needs_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_start_o && flash_op_o == 2'd3) |-> $past(prog_mode_i));

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[13] && !(wr_en_i && !rd_data_o[15] && !wr_data_i[15])) |=> rd_data_o[13]);
endmodule

bind nvm_seq_ctrl nvm_seq_chk u_chk (.*);

// File: tb/tb_nvm_seq_ctrl.sv
module tb_nvm_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 3, TR = 5, TP = 7, TB = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        prog_mode = 1'b0;
  logic        abort = 1'b0;
  logic        f_start, f_busy, done;
  logic [1:0]  f_op;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_seq_ctrl #(.T_WORD(TW), .T_ROW(TR), .T_PAGE(TP), .T_BULK(TB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .prog_mode_i(prog_mode), .abort_i(abort),
    .flash_start_o(f_start), .flash_op_o(f_op), .flash_busy_o(f_busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic bit is_impl(input logic [3:0] c);
    return c == 4'h1 || c == 4'h2 || c == 4'h3 || c == 4'hF;
  endfunction

  function automatic bit is_legal(input bit e, input logic [3:0] c, input bit pm);
    return (!e && (c == 4'h3 || c == 4'h1)) || (e && c == 4'h2) || (e && c == 4'hF && pm);
  endfunction

  function automatic int op_code(input logic [3:0] c);
    case (c) 4'h3: return 0; 4'h1: return 1; 4'h2: return 2; default: return 3; endcase
  endfunction

  function automatic int dur(input logic [3:0] c);
    case (c) 4'h3: return TW; 4'h1: return TR; 4'h2: return TP; default: return TB; endcase
  endfunction

  // prep write clears error, then the start write; observes the whole run
  task automatic run_cmd(input bit arm, input bit e, input logic [3:0] c, input bit pm);
    logic [15:0] f;
    bit bad, legal, mism;
    int cnt;
    f = {1'b0, arm, 7'b0, e, 2'b0, c};
    prog_mode = pm;
    wr(f);
    wr(f | 16'h8000);
    bad   = !arm || !is_impl(c) || (e && c == 4'hF && !pm);
    mism  = !bad && !is_legal(e, c, pm);
    legal = !bad && !mism;
    chk(f_start == legal, bad ? "R3 start" : (mism ? "R4 start" : "R5 start"), f_start, legal);
    chk(rd_data[13] == bad, bad ? "R3 err" : (mism ? "R4 err" : "R6 err"), rd_data[13], bad);
    if (legal) begin
      chk(f_op == 2'(op_code(c)), "R5 op", f_op, op_code(c));
      chk(f_busy == 1'b1, "R5 busy", f_busy, 1);
    end
    cnt = 0;
    while (rd_data[15] && cnt < 200) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == (legal ? dur(c) : 1), legal ? "R6 duration" : (bad ? "R3 duration" : "R4 duration"),
        cnt, legal ? dur(c) : 1);
    chk(done == legal, legal ? "R6 done" : "R4 done", done, legal);
    chk(rd_data[13] == bad, "R6 err after", rd_data[13], bad);
    prog_mode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(rd_data == 16'h0, "R1 reg", rd_data, 0);
    chk(!f_start && !f_busy && !done, "R1 outputs", {f_start, f_busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 16'h0, "R1 reg after release", rd_data, 0);

    // R2: all non-start bits written
    wr(16'h7FFF);
    chk(rd_data == 16'h604F, "R2 readback", rd_data, 16'h604F);
    wr(16'h0000);
    chk(rd_data == 16'h0000, "R2 clear", rd_data, 0);

    // R3/R4/R5/R6 sweep: every code, both selectors, both modes, enable on
    for (int pm = 0; pm < 2; pm++)
      for (int e = 0; e < 2; e++)
        for (int c = 0; c < 16; c++)
          run_cmd(1'b1, 1'(e), 4'(c), 1'(pm));
    // R3: enable off with legal pairs
    run_cmd(1'b0, 1'b0, 4'h3, 1'b1);
    run_cmd(1'b0, 1'b1, 4'h2, 1'b1);
    run_cmd(1'b0, 1'b1, 4'hF, 1'b1);

    // R7: writes during a row program are ignored
    wr(16'h4001);
    wr(16'hC001);
    wr(16'h204E);
    chk((rd_data & 16'h7FFF) == 16'h4001, "R7 fields", rd_data, 16'hC001);
    chk(rd_data[15] == 1'b1, "R7 go held", rd_data[15], 1);
    wr(16'h0000);
    chk(rd_data[15] == 1'b1 && rd_data[13] == 1'b0, "R7 no sw clear", rd_data, 16'hC001);
    while (rd_data[15]) @(negedge clk);
    chk(done == 1'b1, "R7 done", done, 1);

    // R8: abort mid-operation
    wr(16'h4003);
    wr(16'hC003);
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(rd_data[15] == 1'b0 && !f_busy, "R8 stop", {rd_data[15], f_busy}, 0);
    chk(rd_data[13] == 1'b1, "R8 err", rd_data[13], 1);
    chk(done == 1'b0, "R8 no done", done, 0);

    // R9: error survives a legal start
    wr(16'hC003);
    chk(f_start == 1'b1, "R9 start", f_start, 1);
    while (rd_data[15]) @(negedge clk);
    chk(rd_data[13] == 1'b1, "R9 sticky", rd_data[13], 1);
    wr(16'h4003);
    chk(rd_data[13] == 1'b0, "R9 sw clear", rd_data[13], 0);

    // R8: abort in the expiry cycle wins
    wr(16'hC003);
    repeat (TW - 1) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(done == 1'b0 && rd_data[13] == 1'b1, "R8 abort beats expiry", {done, rd_data[13]}, 1);

    // R8: abort while idle
    wr(16'h4003);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    @(negedge clk);
    chk(rd_data == 16'h4003 && !f_busy && !done, "R8 idle abort", rd_data, 16'h4003);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule